// File: doc/BRIEF.md
# Partitioned Tagged Content-Addressable Memory

This block is a small content-addressable memory whose entries each hold a 64-bit data word and a two-bit tag. The tag gates every compare: an entry takes part only when its tag equals the condition being searched for. A static partition code divides each word into a compare part and an associated-data part on 16-bit boundaries. The associated-data bits are stored and read back like ordinary memory but never take part in a compare.

A host drives one operation per clock on a simple strobe-and-opcode interface. Loading the comparand or a mask register starts a compare against valid entries using the newly loaded value. A forced compare searches for any chosen tag. The block reports a registered match flag, a multiple-match flag and the lowest-numbered matching address. Direct writes and reads can take their address from the operation itself, from an address register, from the lowest empty entry or from the last match. A write can be masked by either mask register.

Top module: `tagcam`

## Requirements
- R1: After reset every entry is tagged empty (01) with data 0. matchFlag, multiFlag and matchAddr are 0, fullFlag is 0, nextFree is 0, rdData is 0 and rdTag is 01.
- R2: The tag codes are 00 valid, 01 empty, 10 skip and 11 associated-data. A write (opCode 4) stores opData and sets the entry's tag to opTag. A read (opCode 5) presents the entry's data on rdData and its tag on rdTag one clock later, and both hold until the next read.
- R3: The write mask is selected by opSel: 00 none, 01 mask register 0, 10 mask register 1, 11 both. Data bits whose mask bit is 1 keep their old value.
- R4: opSrc picks the access address: 00 opAddr, 01 the address register (loaded from opAddr by opCode 6), 10 nextFree, 11 matchAddr. A write through source 10 while fullFlag is 1 is dropped. A write through source 11 while matchFlag is 0 is also dropped.
- R5: cfgSplit[1:0] gives the number of 16-bit segments that hold associated data. cfgSplit[2]=0 places them at the least-significant end and 1 at the most-significant end. Those bits are excluded from every compare. Code 000 makes all 64 bits compare bits, and code 001 makes the lower 16 bits associated data.
- R6: Loading the comparand (opCode 1, from opData) launches a compare against entries tagged valid only, and that compare uses the new comparand.
- R7: Loading mask register opSel[0] (opCode 2) launches the same compare using the new mask value. cfgMaskSel selects the compare mask: 00 none, 01 mask 0, 10 mask 1, 11 both. A mask bit of 1 excludes that data bit.
- R8: A forced compare (opCode 3) searches for entries whose tag equals opTag. When opTag is empty (01), all data bits are ignored.
- R9: matchAddr is the lowest-numbered matching entry. multiFlag is 1 exactly when two or more entries match.
- R10: nextFree is the lowest-numbered empty entry, or 0 when none is empty. fullFlag is 1 exactly when no entry is empty.
- R11: The compare results appear one clock after the launching operation and hold until the next compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSplit | input | 3 | Compare / associated-data partition code |
| cfgMaskSel | input | 2 | Mask register(s) applied to compares |
| opValid | input | 1 | Operation strobe |
| opCode | input | 3 | Operation code |
| opData | input | 64 | Write data, comparand or mask value |
| opAddr | input | 4 | Explicit address |
| opSrc | input | 2 | Access address source |
| opSel | input | 2 | Write-mask select; bit 0 picks the mask to load |
| opTag | input | 2 | Tag to write, or the forced-compare target |
| matchFlag | output | 1 | At least one entry matched |
| multiFlag | output | 1 | Two or more entries matched |
| matchAddr | output | 4 | Lowest matching entry |
| nextFree | output | 4 | Lowest empty entry |
| fullFlag | output | 1 | No entry is empty |
| rdData | output | 64 | Data from the last read |
| rdTag | output | 2 | Tag from the last read |

## Verification
The compare results, rdData and rdTag change one clock after the edge that accepts the operation. nextFree and fullFlag follow the tag storage, so they also settle one clock after a write. The bench drives each operation on a falling edge and lets the next rising edge consume it. It then compares every output with a bench model shortly after that edge, before the next operation is driven, so each result is checked in the cycle where it first becomes due. Address sources, write masks and compare masks are resolved in the model from its own state as it stood before the operation.

// File: rtl/tagcam_pkg.sv
package tagcam_pkg;
  localparam int SEG_W = 16;

  typedef enum logic [1:0] {
    TAG_VALID = 2'b00,
    TAG_EMPTY = 2'b01,
    TAG_SKIP  = 2'b10,
    TAG_RAM   = 2'b11
  } tag_e;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_LDCMP  = 3'd1,
    OP_LDMASK = 3'd2,
    OP_CMPF   = 3'd3,
    OP_WRITE  = 3'd4,
    OP_READ   = 3'd5,
    OP_LDADDR = 3'd6,
    OP_RSV    = 3'd7
  } op_e;

  typedef struct packed {
    logic       wrEn;
    logic       rdEn;
    logic       cmpEn;
    logic       ldCmp;
    logic       ldMask0;
    logic       ldMask1;
    tag_e       tgt;
    logic [1:0] wmSel;
  } strobe_t;
endpackage

// File: rtl/tagcam_prienc.sv
module tagcam_prienc #(
  parameter int N = 16,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic          multi,
  output logic [AW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = AW'(i);
    end
  end

  assign any   = |vec;
  assign multi = |(vec & (vec - N'(1)));
endmodule

// File: rtl/tagcam_ctrl.sv
module tagcam_ctrl import tagcam_pkg::*; #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [1:0]        opSrc,
  input  logic [1:0]        opSel,
  input  logic [1:0]        opTag,
  input  logic              fullFlag,
  input  logic              matchFlag,
  input  logic [ADDR_W-1:0] matchAddr,
  input  logic [ADDR_W-1:0] nextFree,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] accAddr
);
  logic [ADDR_W-1:0] addrReg;
  logic              srcBlocked;
  op_e               op;

  assign op = op_e'(opCode);

  always_ff @(posedge clk) begin
    if (!rstN) addrReg <= '0;
    else if (opValid && op == OP_LDADDR) addrReg <= opAddr;
  end

  always_comb begin
    case (opSrc)
      2'b01:   accAddr = addrReg;
      2'b10:   accAddr = nextFree;
      2'b11:   accAddr = matchAddr;
      default: accAddr = opAddr;
    endcase
    srcBlocked = (opSrc == 2'b10 && fullFlag) || (opSrc == 2'b11 && !matchFlag);
  end

  always_comb begin
    strb       = '0;
    strb.tgt   = TAG_VALID;
    strb.wmSel = opSel;
    if (opValid) begin
      case (op)
        OP_LDCMP:  begin strb.ldCmp = 1'b1; strb.cmpEn = 1'b1; end
        OP_LDMASK: begin
          strb.ldMask0 = !opSel[0];
          strb.ldMask1 = opSel[0];
          strb.cmpEn   = 1'b1;
        end
        OP_CMPF:   begin strb.cmpEn = 1'b1; strb.tgt = tag_e'(opTag); end
        OP_WRITE:  begin strb.wrEn = !srcBlocked; strb.tgt = tag_e'(opTag); end
        OP_READ:   strb.rdEn = 1'b1;
        default:   ;
      endcase
    end
  end

  // R4: a write through the free pointer never lands when storage is full
  a_r4_no_write_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && opSrc == 2'b10) |-> !fullFlag);
  // R4: a write through the match pointer needs a prior match
  a_r4_match_src_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && opSrc == 2'b11) |-> matchFlag);
  a_r11_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrEn, strb.rdEn, strb.cmpEn}));
endmodule

// File: rtl/tagcam_dp.sv
module tagcam_dp import tagcam_pkg::*; #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgSplit,
  input  logic [1:0]        cfgMaskSel,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] opData,
  output logic              matchFlag,
  output logic              multiFlag,
  output logic [ADDR_W-1:0] matchAddr,
  output logic [ADDR_W-1:0] nextFree,
  output logic              fullFlag,
  output logic [DATA_W-1:0] rdData,
  output tag_e              rdTag
);
  localparam int SEGS = DATA_W / SEG_W;

  logic [DATA_W-1:0] dataMem [DEPTH];
  tag_e              tagMem  [DEPTH];
  logic [DATA_W-1:0] cmpReg, mask0, mask1;
  logic [DATA_W-1:0] effCmp, effM0, effM1, selMask, careMask, ramMask, wrMask;
  logic [DEPTH-1:0]  hitVec, emptyVec;
  logic              hitAny, hitMulti, freeAny;
  logic [ADDR_W-1:0] hitIdx;
  int                nRam;

  assign nRam = int'(cfgSplit[1:0]);

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    logic isRam;
    assign isRam = cfgSplit[2] ? (s >= SEGS - nRam) : (s < nRam);
    assign ramMask[s*SEG_W +: SEG_W] = {SEG_W{isRam}};
  end

  always_comb begin
    effCmp = strb.ldCmp   ? opData : cmpReg;
    effM0  = strb.ldMask0 ? opData : mask0;
    effM1  = strb.ldMask1 ? opData : mask1;
    case (cfgMaskSel)
      2'b01:   selMask = effM0;
      2'b10:   selMask = effM1;
      2'b11:   selMask = effM0 | effM1;
      default: selMask = '0;
    endcase
    careMask = ~(ramMask | selMask);
    if (strb.tgt == TAG_EMPTY) careMask = '0;
    case (strb.wmSel)
      2'b01:   wrMask = mask0;
      2'b10:   wrMask = mask1;
      2'b11:   wrMask = mask0 | mask1;
      default: wrMask = '0;
    endcase
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign hitVec[i]   = (tagMem[i] == strb.tgt) &&
                         (((dataMem[i] ^ effCmp) & careMask) == '0);
    assign emptyVec[i] = (tagMem[i] == TAG_EMPTY);
  end

  tagcam_prienc #(.N(DEPTH)) u_hitEnc (
    .vec(hitVec), .any(hitAny), .multi(hitMulti), .idx(hitIdx));

  logic freeMulti;
  tagcam_prienc #(.N(DEPTH)) u_freeEnc (
    .vec(emptyVec), .any(freeAny), .multi(freeMulti), .idx(nextFree));

  assign fullFlag = !freeAny;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        dataMem[i] <= '0;
        tagMem[i]  <= TAG_EMPTY;
      end
      cmpReg <= '0; mask0 <= '0; mask1 <= '0;
      matchFlag <= 1'b0; multiFlag <= 1'b0; matchAddr <= '0;
      rdData <= '0; rdTag <= TAG_EMPTY;
    end else begin
      if (strb.ldCmp)   cmpReg <= opData;
      if (strb.ldMask0) mask0  <= opData;
      if (strb.ldMask1) mask1  <= opData;
      if (strb.wrEn) begin
        dataMem[accAddr] <= (dataMem[accAddr] & wrMask) | (opData & ~wrMask);
        tagMem[accAddr]  <= strb.tgt;
      end
      if (strb.rdEn) begin
        rdData <= dataMem[accAddr];
        rdTag  <= tagMem[accAddr];
      end
      if (strb.cmpEn) begin
        matchFlag <= hitAny;
        multiFlag <= hitMulti;
        matchAddr <= hitIdx;
      end
    end
  end

  // R9: several hits imply at least one hit
  a_r9_multi_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    multiFlag |-> matchFlag);
  // R9: the reported address carries the searched tag
  a_r9_addr_has_target: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmpEn |=> (!matchFlag || tagMem[matchAddr] == $past(strb.tgt)));
  // R8: searching for empty entries depends on the tags alone
  a_r8_empty_search: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmpEn && strb.tgt == TAG_EMPTY) |=> (matchFlag == !$past(fullFlag)));
  // R10: the free pointer names an empty entry
  a_r10_free_is_empty: assert property (@(posedge clk) disable iff (!rstN)
    !fullFlag |-> tagMem[nextFree] == TAG_EMPTY);
  // R11: results stay put between compares
  a_r11_results_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cmpEn |=> ($stable(matchFlag) && $stable(multiFlag) && $stable(matchAddr)));
endmodule

// File: rtl/tagcam.sv
module tagcam import tagcam_pkg::*; #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 64,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgSplit,
  input  logic [1:0]        cfgMaskSel,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [DATA_W-1:0] opData,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [1:0]        opSrc,
  input  logic [1:0]        opSel,
  input  logic [1:0]        opTag,
  output logic              matchFlag,
  output logic              multiFlag,
  output logic [ADDR_W-1:0] matchAddr,
  output logic [ADDR_W-1:0] nextFree,
  output logic              fullFlag,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        rdTag
);
  strobe_t           strb;
  logic [ADDR_W-1:0] accAddr;
  tag_e              rdTagE;

  tagcam_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opAddr(opAddr), .opSrc(opSrc), .opSel(opSel), .opTag(opTag),
    .fullFlag(fullFlag), .matchFlag(matchFlag), .matchAddr(matchAddr),
    .nextFree(nextFree), .strb(strb), .accAddr(accAddr));

  tagcam_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgSplit(cfgSplit), .cfgMaskSel(cfgMaskSel),
    .strb(strb), .accAddr(accAddr), .opData(opData),
    .matchFlag(matchFlag), .multiFlag(multiFlag), .matchAddr(matchAddr),
    .nextFree(nextFree), .fullFlag(fullFlag), .rdData(rdData), .rdTag(rdTagE));

  assign rdTag = rdTagE;
endmodule

// File: tb/tagcam_tb.sv
module tagcam_tb;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cfgSplit = '0;
  logic [1:0]  cfgMaskSel = '0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [63:0] opData = '0;
  logic [3:0]  opAddr = '0;
  logic [1:0]  opSrc = '0, opSel = '0, opTag = '0;
  logic        matchFlag, multiFlag, fullFlag;
  logic [3:0]  matchAddr, nextFree;
  logic [63:0] rdData;
  logic [1:0]  rdTag;

  tagcam u_dut (.*);

  always #5 clk = ~clk;

  int nChk = 0, nFail = 0;
  logic [63:0] mD [D];
  logic [1:0]  mT [D];
  logic [63:0] mCmp, mM0, mM1, mRd;
  logic [3:0]  mAddrR, mMA;
  logic        mMF, mMult;
  logic [1:0]  mRdT;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  function automatic logic [63:0] ramMaskOf(logic [2:0] c);
    logic [63:0] m = '0;
    int n = int'(c[1:0]);
    for (int s = 0; s < 4; s++)
      if (c[2] ? (s >= 4 - n) : (s < n)) m[s*16 +: 16] = 16'hFFFF;
    return m;
  endfunction

  function automatic logic [3:0] freeOf();
    for (int i = 0; i < D; i++) if (mT[i] == 2'b01) return 4'(i);
    return 4'd0;
  endfunction

  function automatic logic fullOf();
    for (int i = 0; i < D; i++) if (mT[i] == 2'b01) return 1'b0;
    return 1'b1;
  endfunction

  task automatic modelCompare(logic [1:0] tgt, logic [63:0] c, logic [63:0] m0, logic [63:0] m1);
    logic [63:0] sm, care;
    int cnt = 0;
    case (cfgMaskSel)
      2'b01: sm = m0; 2'b10: sm = m1; 2'b11: sm = m0 | m1; default: sm = '0;
    endcase
    care = ~(ramMaskOf(cfgSplit) | sm);
    if (tgt == 2'b01) care = '0;
    mMA = '0;
    for (int i = D - 1; i >= 0; i--)
      if (mT[i] == tgt && ((mD[i] ^ c) & care) == '0) begin
        mMA = 4'(i); cnt++;
      end
    mMF = cnt > 0; mMult = cnt > 1;
  endtask

  task automatic modelOp(logic [2:0] op, logic [63:0] d, logic [3:0] a,
                         logic [1:0] src, logic [1:0] sel, logic [1:0] tg);
    logic [3:0]  ea;
    logic [63:0] wm;
    logic        blk;
    case (src)
      2'b01: ea = mAddrR; 2'b10: ea = freeOf(); 2'b11: ea = mMA; default: ea = a;
    endcase
    blk = (src == 2'b10 && fullOf()) || (src == 2'b11 && !mMF);
    case (op)
      3'd1: begin mCmp = d; modelCompare(2'b00, mCmp, mM0, mM1); end
      3'd2: begin
        if (sel[0]) mM1 = d; else mM0 = d;
        modelCompare(2'b00, mCmp, mM0, mM1);
      end
      3'd3: modelCompare(tg, mCmp, mM0, mM1);
      3'd4: if (!blk) begin
        case (sel)
          2'b01: wm = mM0; 2'b10: wm = mM1; 2'b11: wm = mM0 | mM1; default: wm = '0;
        endcase
        mD[ea] = (mD[ea] & wm) | (d & ~wm);
        mT[ea] = tg;
      end
      3'd5: begin mRd = mD[ea]; mRdT = mT[ea]; end
      3'd6: mAddrR = a;
      default: ;
    endcase
  endtask

  task automatic checkAll();
    chk("R9 matchFlag", 64'(matchFlag), 64'(mMF));
    chk("R9 multiFlag", 64'(multiFlag), 64'(mMult));
    chk("R11 matchAddr", 64'(matchAddr), 64'(mMA));
    chk("R10 fullFlag", 64'(fullFlag), 64'(fullOf()));
    chk("R10 nextFree", 64'(nextFree), 64'(freeOf()));
    chk("R2 rdData", rdData, mRd);
    chk("R2 rdTag", 64'(rdTag), 64'(mRdT));
  endtask

  // drive at a falling edge, consume at the rising edge, check 3 ns later
  task automatic step(logic [2:0] op, logic [63:0] d, logic [3:0] a,
                      logic [1:0] src, logic [1:0] sel, logic [1:0] tg);
    opValid = 1'b1; opCode = op; opData = d; opAddr = a;
    opSrc = src; opSel = sel; opTag = tg;
    modelOp(op, d, a, src, sel, tg);
    @(posedge clk);
    #3;
    opValid = 1'b0; opCode = 3'd0;
    checkAll();
    @(negedge clk);
  endtask

  localparam logic [63:0] A = 64'h1234_5678_9ABC_DEF0;
  logic [63:0] pool [4];

  initial begin
    #(200000 * 10);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < D; i++) begin mD[i] = '0; mT[i] = 2'b01; end
    mCmp = '0; mM0 = '0; mM1 = '0; mRd = '0; mRdT = 2'b01;
    mAddrR = '0; mMA = '0; mMF = 1'b0; mMult = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1 matchFlag", 64'(matchFlag), 64'd0);
    chk("R1 multiFlag", 64'(multiFlag), 64'd0);
    chk("R1 fullFlag", 64'(fullFlag), 64'd0);
    chk("R1 nextFree", 64'(nextFree), 64'd0);
    chk("R1 rdData", rdData, 64'd0);
    chk("R1 rdTag", 64'(rdTag), 64'd1);
    @(negedge clk);

    // R2: write and read back
    step(3'd4, A, 4'd2, 2'b00, 2'b00, 2'b00);
    step(3'd4, A ^ 64'h00FF, 4'd5, 2'b00, 2'b00, 2'b00);
    step(3'd5, 64'd0, 4'd5, 2'b00, 2'b00, 2'b00);
    chk("R2 read data", rdData, A ^ 64'h00FF);
    // R5: split 000 full compare, 001 lower 16 ignored, 101 upper 16 ignored
    cfgSplit = 3'b000;
    step(3'd1, A, 4'd0, 2'b00, 2'b00, 2'b00);
    chk("R5 all-compare single", {62'd0, multiFlag, matchFlag}, 64'b01);
    cfgSplit = 3'b001;
    step(3'd1, A, 4'd0, 2'b00, 2'b00, 2'b00);
    chk("R5 low RAM multi", {56'd0, matchAddr, 2'b00, multiFlag, matchFlag}, {56'd0, 4'd2, 4'b0011});
    cfgSplit = 3'b101;
    step(3'd1, A, 4'd0, 2'b00, 2'b00, 2'b00);
    chk("R5 high RAM single", 64'(multiFlag), 64'd0);
    cfgSplit = 3'b000;
    // R6: skip-tagged entry ignored by the automatic compare
    step(3'd4, A, 4'd1, 2'b00, 2'b00, 2'b10);
    step(3'd1, A, 4'd0, 2'b00, 2'b00, 2'b00);
    chk("R6 skip ignored", 64'(matchAddr), 64'd2);
    // R8: forced compare on skip and on empty
    step(3'd3, 64'd0, 4'd0, 2'b00, 2'b00, 2'b10);
    chk("R8 forced skip", 64'(matchAddr), 64'd1);
    step(3'd3, 64'd0, 4'd0, 2'b00, 2'b00, 2'b01);
    chk("R8 forced empty", {60'd0, matchAddr}, 64'd0);
    // R7: mask load triggers compare with the new mask
    cfgMaskSel = 2'b01;
    step(3'd1, A ^ 64'hFF00_0000_0000_0000, 4'd0, 2'b00, 2'b00, 2'b00);
    chk("R7 no mask hit", 64'(matchFlag), 64'd0);
    step(3'd2, 64'hFF00_0000_0000_0000, 4'd0, 2'b00, 2'b00, 2'b00);
    chk("R7 new mask hit", 64'(matchFlag), 64'd1);
    // R3: masked write keeps masked bits
    step(3'd4, 64'd0, 4'd2, 2'b00, 2'b01, 2'b00);
    step(3'd5, 64'd0, 4'd2, 2'b00, 2'b00, 2'b00);
    chk("R3 masked write", rdData, A & 64'hFF00_0000_0000_0000);
    cfgMaskSel = 2'b00;
    // R4: address register, next-free and match sources
    step(3'd6, 64'd0, 4'd9, 2'b00, 2'b00, 2'b00);
    step(3'd4, 64'h77, 4'd0, 2'b01, 2'b00, 2'b11);
    step(3'd5, 64'd0, 4'd9, 2'b00, 2'b00, 2'b00);
    chk("R4 addr reg write", {rdTag, rdData[61:0]}, {2'b11, 62'h77});
    for (int i = 0; i < D; i++) step(3'd4, 64'(i), 4'd0, 2'b10, 2'b00, 2'b00);
    chk("R10 full", 64'(fullFlag), 64'd1);
    step(3'd4, 64'hDEAD, 4'd0, 2'b10, 2'b00, 2'b00);
    step(3'd1, 64'hDEAD, 4'd0, 2'b00, 2'b00, 2'b00);
    chk("R4 dropped when full", 64'(matchFlag), 64'd0);
    step(3'd4, 64'hBEEF, 4'd0, 2'b11, 2'b00, 2'b01);
    chk("R4 match src blocked", 64'(fullFlag), 64'd1);

    // random phase
    pool[0] = A; pool[1] = ~A; pool[2] = 64'h0; pool[3] = 64'hCAFE_0000_1111_2222;
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      logic [63:0] d = pool[$urandom % 4];
      logic [2:0] op;
      if ($urandom % 3 == 0) d ^= {48'd0, 16'($urandom % 4)};
      if ($urandom % 5 == 0) d ^= {16'($urandom % 4), 48'd0};
      if ($urandom % 20 == 0) cfgSplit = 3'($urandom);
      if ($urandom % 20 == 0) cfgMaskSel = 2'($urandom);
      if (r < 35) op = 3'd4;
      else if (r < 55) op = 3'd1;
      else if (r < 70) op = 3'd3;
      else if (r < 80) op = 3'd5;
      else if (r < 88) begin
        op = 3'd2;
        d = ($urandom % 2) ? 64'h0 : 64'h0000_0000_0000_FFFF;
      end
      else if (r < 95) op = 3'd6;
      else op = 3'd0;
      step(op, d, 4'($urandom), 2'($urandom), 2'($urandom), 2'($urandom));
    end
    summary();
  end
endmodule